// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block is a CPU-bus peripheral that drives and samples three 8-bit parallel ports, named A, B and C. The CPU reaches it through an 8-bit data bus, a 2-bit register address, an active-low chip select, an active-low read strobe and an active-low write strobe. Port C works as two 4-bit halves. Each half has its own direction, so one half can drive while the other half samples.

A write-only control register sets the direction of the four port groups. The same register address also accepts a second command format, which sets or clears one port C bit. Every port has an output latch that holds its value between writes. A read returns the latch when the port drives, and the live pins when the port samples.

All bus writes are synchronous. A write is taken on each rising clock edge at which chip select and the write strobe are both low. Read data is combinational while chip select and the read strobe are low.

Top module: `pio_ctrl`

## Requirements
- R1: After the asynchronous reset, every port group is an input (all `*_oe_o` bits are 0), every output latch is 0, and `data_o` is 0.
- R2: A write of a control word with bit 7 = 1 to address 3 sets the directions. Bit 4 sets port A, bit 3 sets the C upper half, bit 1 sets port B and bit 0 sets the C lower half. A 1 means input, which drives the matching `*_oe_o` bits to 0. A 0 means output, which drives them to 1.
- R3: A mode write (bit 7 = 1) clears the latches of ports A, B and C to 0.
- R4: A write to address 0, 1 or 2 (port A, B or C) loads that port's latch. The latch appears on `pa_o`, `pb_o` or `pc_o` and holds after the strobe ends.
- R5: A control word with bit 7 = 0 at address 3 writes bit 0 into the port C latch bit whose index is given by bits 3:1. Every other latch bit and every direction stay unchanged.
- R6: A read of port A, B or C returns the live pins where that group is an input, and the latch where it is an output. Each half of port C follows its own direction.
- R7: A read of address 3 returns 0x00 and never the control register contents.
- R8: A write strobe while `cs_ni` is high changes no latch and no direction.
- R9: `data_o` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select: 0=A, 1=B, 2=C, 3=control |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C drive enable |

## Verification
The bench builds the block with its default 8-bit port width, so a port C bit index has 3 bits and each half has 4 bits. At this size the bench can sweep all 16 direction combinations. For each combination it writes patterns, reads every address against driven pin values, and checks that the mode write cleared the latches. It also walks all 8 port C bit indices through set and then clear. Together these cover every mixed-direction case of the port C halves and every target of the single-bit command.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);
  localparam int N_PORT = 3;

  localparam int CW_MODE = 7;
  localparam int CW_A    = 4;
  localparam int CW_CU   = 3;
  localparam int CW_B    = 1;
  localparam int CW_CL   = 0;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [N_PORT-1:0] port_wr_o,
  output logic              mode_wr_o,
  output logic              bit_wr_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              bit_val_o,
  output logic              rd_en_o
);
  logic wr_en;
  sel_e sel;

  assign sel     = sel_e'(addr_i);
  assign wr_en   = !cs_ni && !wr_ni;
  assign rd_en_o = !cs_ni && !rd_ni;

  always_comb begin
    port_wr_o = '0;
    mode_wr_o = 1'b0;
    bit_wr_o  = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_A:    port_wr_o[0] = 1'b1;
        SEL_B:    port_wr_o[1] = 1'b1;
        SEL_C:    port_wr_o[2] = 1'b1;
        SEL_CTRL: begin
          mode_wr_o = data_i[CW_MODE];
          bit_wr_o  = !data_i[CW_MODE];
        end
        default: ;
      endcase
    end
  end

  assign bit_idx_o = data_i[IDX_W:1];
  assign bit_val_o = data_i[0];
endmodule

// File: rtl/pio_dir_reg.sv
module pio_dir_reg
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [PORT_W-1:0] data_i,
  output dir_t              dir_o
);
  dir_t dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
    end else if (mode_wr_i) begin
      dir_q.a_in  <= data_i[CW_A];
      dir_q.b_in  <= data_i[CW_B];
      dir_q.cu_in <= data_i[CW_CU];
      dir_q.cl_in <= data_i[CW_CL];
    end
  end

  assign dir_o = dir_q;

  // R2
  mode_sets_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (dir_o.a_in == $past(data_i[CW_A])) && (dir_o.b_in == $past(data_i[CW_B]))
                  && (dir_o.cu_in == $past(data_i[CW_CU])) && (dir_o.cl_in == $past(data_i[CW_CL])));
endmodule

// File: rtl/pio_latches.sv
module pio_latches
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PORT-1:0] port_wr_i,
  input  logic              mode_wr_i,
  input  logic              bit_wr_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [N_PORT-1:0][PORT_W-1:0] lat_o
);
  logic [N_PORT-1:0][PORT_W-1:0] lat_q;

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    if (g == N_PORT - 1) begin : g_bitcmd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            lat_q[g] <= '0;
        else if (mode_wr_i)     lat_q[g] <= '0;
        else if (port_wr_i[g])  lat_q[g] <= data_i;
        else if (bit_wr_i)      lat_q[g][bit_idx_i] <= bit_val_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            lat_q[g] <= '0;
        else if (mode_wr_i)     lat_q[g] <= '0;
        else if (port_wr_i[g])  lat_q[g] <= data_i;
      end
    end
  end

  assign lat_o = lat_q;

  // R3
  mode_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (lat_o == '0));

  // R4
  port_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i[0] |=> (lat_o[0] == $past(data_i)));

  // R5
  bit_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_wr_i |=> (lat_o[N_PORT-1][$past(bit_idx_i)] == $past(bit_val_i)) && $stable(lat_o[0]));
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
(
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  dir_t              dir_i,
  input  logic [N_PORT-1:0][PORT_W-1:0] lat_i,
  input  logic [PORT_W-1:0] pa_i,
  input  logic [PORT_W-1:0] pb_i,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] data_o
);
  logic [PORT_W-1:0] a_val, b_val, c_val;
  logic [1:0]        c_half_in;

  assign c_half_in = {dir_i.cu_in, dir_i.cl_in};
  assign a_val = dir_i.a_in ? pa_i : lat_i[0];
  assign b_val = dir_i.b_in ? pb_i : lat_i[1];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign c_val[h*HALF_W +: HALF_W] = c_half_in[h] ? pc_i[h*HALF_W +: HALF_W]
                                                    : lat_i[2][h*HALF_W +: HALF_W];
  end

  always_comb begin
    data_o = '0;
    if (rd_en_i) begin
      unique case (sel_e'(addr_i))
        SEL_A:    data_o = a_val;
        SEL_B:    data_o = b_val;
        SEL_C:    data_o = c_val;
        SEL_CTRL: data_o = '0;
        default:  data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  logic [N_PORT-1:0]             port_wr;
  logic                          mode_wr, bit_wr, bit_val, rd_en;
  logic [IDX_W-1:0]              bit_idx;
  dir_t                          dir;
  logic [N_PORT-1:0][PORT_W-1:0] lat;

  pio_bus_decode u_dec (
    .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .port_wr_o(port_wr), .mode_wr_o(mode_wr), .bit_wr_o(bit_wr),
    .bit_idx_o(bit_idx), .bit_val_o(bit_val), .rd_en_o(rd_en)
  );

  pio_dir_reg u_dir (
    .clk_i, .rst_ni, .mode_wr_i(mode_wr), .data_i, .dir_o(dir)
  );

  pio_latches u_lat (
    .clk_i, .rst_ni, .port_wr_i(port_wr), .mode_wr_i(mode_wr), .bit_wr_i(bit_wr),
    .bit_idx_i(bit_idx), .bit_val_i(bit_val), .data_i, .lat_o(lat)
  );

  pio_read_mux u_rd (
    .rd_en_i(rd_en), .addr_i, .dir_i(dir), .lat_i(lat),
    .pa_i, .pb_i, .pc_i, .data_o
  );

  assign pa_o    = lat[0];
  assign pb_o    = lat[1];
  assign pc_o    = lat[2];
  assign pa_oe_o = {PORT_W{!dir.a_in}};
  assign pb_oe_o = {PORT_W{!dir.b_in}};
  assign pc_oe_o = {{HALF_W{!dir.cu_in}}, {HALF_W{!dir.cl_in}}};

  // R8
  unselected_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(lat) && $stable(dir));

  // R5
  bit_cmd_keeps_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_wr |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));
endmodule

// File: tb/tb_pio_ctrl.sv
module tb_pio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pb_o, pc_o, pa_oe, pb_oe, pc_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic a_in, b_in, cu_in, cl_in;
  logic [7:0] la, lb, lc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_ctrl dut (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i(addr), .data_i(din), .data_o(dout),
    .pa_i, .pa_o, .pa_oe_o(pa_oe), .pb_i, .pb_o, .pb_oe_o(pb_oe),
    .pc_i, .pc_o, .pc_oe_o(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; din = d; cs_ni = !sel; wr_ni = 1'b0;
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_ni = 1'b0; rd_ni = 1'b0;
    #1 d = dout;
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return a_in ? pa_i : la;
      2'd1: return b_in ? pb_i : lb;
      2'd2: return {cu_in ? pc_i[7:4] : lc[7:4], cl_in ? pc_i[3:0] : lc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_oe(input string req);
    chk(req, pa_oe, {8{!a_in}});
    chk(req, pb_oe, {8{!b_in}});
    chk(req, pc_oe, {{4{!cu_in}}, {4{!cl_in}}});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    a_in = 1; b_in = 1; cu_in = 1; cl_in = 1; la = 0; lb = 0; lc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pa_o", pa_o, 8'h00); chk("R1 pb_o", pb_o, 8'h00); chk("R1 pc_o", pc_o, 8'h00);
    chk_oe("R1 oe");
    chk("R1 data_o", dout, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      bus_wr(2'd0, 8'h5A); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h96);
      // R2 mode word: bit4 A, bit3 C upper, bit1 B, bit0 C lower
      bus_wr(2'd3, 8'h80 | (8'(m[3]) << 4) | (8'(m[2]) << 3) | (8'(m[1]) << 1) | 8'(m[0]));
      a_in = m[3]; cu_in = m[2]; b_in = m[1]; cl_in = m[0];
      la = 0; lb = 0; lc = 0;
      chk_oe("R2 dir");
      chk("R3 clear A", pa_o, 8'h00); chk("R3 clear B", pb_o, 8'h00); chk("R3 clear C", pc_o, 8'h00);
      la = 8'(m * 17) ^ 8'hA5; lb = ~la; lc = {la[3:0], lb[7:4]};
      bus_wr(2'd0, la); bus_wr(2'd1, lb); bus_wr(2'd2, lc);
      @(negedge clk);
      chk("R4 A", pa_o, la); chk("R4 B", pb_o, lb); chk("R4 C", pc_o, lc);
      pa_i = 8'(m * 29) ^ 8'h3C; pb_i = ~pa_i; pc_i = 8'(m * 53) ^ 8'hF0;
      for (int a = 0; a < 4; a++) begin
        bus_rd(2'(a), rd);
        chk(a == 3 ? "R7 ctrl read" : "R6 port read", rd, exp_rd(2'(a)));
      end
      @(negedge clk);
      chk("R9 idle", dout, 8'h00);
      // R8 unselected writes
      bus_wr(2'd0, ~la, 1'b0); bus_wr(2'd3, 8'h9B, 1'b0); bus_wr(2'd2, 8'h00, 1'b0);
      chk("R8 A", pa_o, la); chk("R8 C", pc_o, lc);
      chk_oe("R8 dir");
    end

    // R5 single-bit commands on all-output config
    bus_wr(2'd3, 8'h80);
    a_in = 0; b_in = 0; cu_in = 0; cl_in = 0; lc = 0;
    bus_wr(2'd0, 8'h77); la = 8'h77;
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd3, 8'((i << 1) | 1));
      lc[i] = 1'b1;
      chk("R5 set", pc_o, lc);
      chk("R5 A kept", pa_o, la);
      chk_oe("R5 dir kept");
    end
    for (int i = 7; i >= 0; i--) begin
      bus_wr(2'd3, 8'(i << 1));
      lc[i] = 1'b0;
      chk("R5 clear", pc_o, lc);
    end
    // R5 with mixed C directions: bit command still hits latch only
    bus_wr(2'd3, 8'h88);
    a_in = 0; b_in = 0; cu_in = 1; cl_in = 0; la = 0; lc = 0;
    bus_wr(2'd3, 8'h0D); lc[6] = 1'b1;
    bus_wr(2'd3, 8'h03); lc[1] = 1'b1;
    chk("R5 mixed", pc_o, lc);
    chk_oe("R5 mixed dir");
    pc_i = 8'hA0;
    bus_rd(2'd2, rd);
    chk("R6 C halves", rd, 8'hA2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule